// File: doc/BRIEF.md
# Lookahead Way Allocation Engine

This engine divides the ways of a shared cache among several applications once per repartitioning epoch. Each application has a hit monitor that keeps a cumulative hit curve: the number of hits the application would have had with k ways, for k from 1 up to the way count. A one-cycle start pulse launches a pass. The engine walks these curves through a single read port, one counter per cycle. It then hands out ways in rounds until none are left.

In each round the engine looks at every application and at every possible extra allocation size that still fits in the remaining budget. It measures the hits gained per extra way and grants the single best (application, size) pair. It does not look at only one extra way at a time, so a curve that is flat for a while and then jumps is still rewarded. Ratios are compared exactly by cross-multiplication, so no divider is needed. If no application would gain anything, the ways are dealt out one at a time in rotation, so every pass finishes.

The per-application results are held steady on the outputs and change together when the pass completes. At that point a done flag rises and stays high until the next start.

Top module: `way_lookahead_alloc`

## Requirements
- R1: After reset, `done` is low, `rd_en` is low and every `ways_given` field is zero.
- R2: A `start` pulse seen while no pass is running begins a pass. `done` is low from the following cycle until the pass completes. In the cycle `done` rises, the fields of `ways_given` sum to exactly NUM_WAYS.
- R3: The gain of raising application a from its current count c to c+d ways is hits_a(c+d) − hits_a(c), with hits_a(0) taken as 0. A negative difference counts as zero gain.
- R4: In each round the grant goes to the candidate with the largest gain/d. The comparison is exact and made without rounding: candidate (g1,d1) beats (g2,d2) only if g1·d2 > g2·d1. A zero gain never wins.
- R5: Among candidates with equal gain per way, the lower application index wins first, then the smaller d.
- R6: Each round grants the winning d ways to the winning application and subtracts them from the remaining budget. A candidate d never exceeds the remaining budget. Rounds repeat until the budget is zero.
- R7: If no candidate has a nonzero gain, the round grants one way to the application named by a rotating pointer. The pointer starts at application 0 on every pass, steps by one after each such grant and wraps after NUM_APPS−1. Rounds with a winning candidate leave the pointer unchanged.
- R8: `ways_given` keeps the previous pass's result while a pass runs. All of its fields change together, on the clock edge that raises `done`.
- R9: Whenever `rd_en` is high, `rd_pos` lies between 1 and NUM_WAYS and names the curve entry of application `rd_app`. `rd_data` is consumed in the same cycle.
- R10: A `start` pulse that arrives while a pass is running has no effect: the running pass ends with the same result it would have had without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a pass |
| rd_en | output | 1 | Read port enable towards the hit monitors |
| rd_app | output | $clog2(NUM_APPS) | Application whose curve is read |
| rd_pos | output | $clog2(NUM_WAYS+1) | Way count whose cumulative hits are read |
| rd_data | input | CNT_W | Cumulative hit count for (`rd_app`, `rd_pos`), same cycle |
| done | output | 1 | High from pass completion until the next accepted start |
| ways_given | output | NUM_APPS*$clog2(NUM_WAYS+1) | Committed ways per application, application 0 in the low field |

## Verification
The bench builds the engine with four applications, eight ways and 12-bit hit counters. With these values, every round size from 1 to the full budget, rotation wrap-around and several rounds per pass all fit in a few hundred cycles per pass. Directed curves cover three cases: a late jump on a curve, which defeats one-way-at-a-time allocation, tie-breaking on identical curves, and falling or all-zero curves that force the rotation path. Randomised monotone curves, with an occasional drop, then exercise many cross-multiplied comparisons, including near-equal ratios. The bench also pulses start during a pass to show that the pass is unaffected.

// File: rtl/way_alloc_pkg.sv
package way_alloc_pkg;

  // Pass sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BASE  = 2'd1,
    ST_SCAN  = 2'd2,
    ST_GRANT = 2'd3
  } wa_state_e;

endpackage

// File: rtl/wa_reset_sync.sv
module wa_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/wa_mu_compare.sv
module wa_mu_compare #(
  parameter int CNT_W = 16,
  parameter int WAY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cand_gain,
  input  logic [WAY_W-1:0] cand_ways,
  input  logic [CNT_W-1:0] best_gain,
  input  logic [WAY_W-1:0] best_ways,
  output logic             better
);

  localparam int PROD_W = CNT_W + WAY_W;

  logic [PROD_W-1:0] cand_scaled;
  logic [PROD_W-1:0] best_scaled;

  // gain/ways ratios compared exactly: cand_gain*best_ways vs best_gain*cand_ways
  always_comb begin
    cand_scaled = PROD_W'(cand_gain) * PROD_W'(best_ways);
    best_scaled = PROD_W'(best_gain) * PROD_W'(cand_ways);
    better      = cand_scaled > best_scaled;
  end

  // R4: a zero gain can never displace the current best
  assert_zero_gain_loses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_gain == '0) |-> !better);

endmodule

// File: rtl/wa_alloc_regs.sv
module wa_alloc_regs #(
  parameter int NUM_APPS = 4,
  parameter int WAY_W    = 5,
  parameter int APP_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      grant_en,
  input  logic [APP_W-1:0]          grant_app,
  input  logic [WAY_W-1:0]          grant_cnt,
  input  logic                      commit,
  output logic [NUM_APPS*WAY_W-1:0] alloc_cur,
  output logic [NUM_APPS*WAY_W-1:0] ways_out
);

  logic [NUM_APPS*WAY_W-1:0] alloc_d;
  logic [NUM_APPS*WAY_W-1:0] alloc_q;
  logic [NUM_APPS*WAY_W-1:0] ways_d;
  logic [NUM_APPS*WAY_W-1:0] ways_q;

  for (genvar a = 0; a < NUM_APPS; a++) begin : g_app
    logic hit;
    assign hit = grant_en && (grant_app == APP_W'(a));

    // working allocation: cleared on a new pass, bumped by grants
    always_comb begin
      alloc_d[a*WAY_W +: WAY_W] = alloc_q[a*WAY_W +: WAY_W];
      if (clr)      alloc_d[a*WAY_W +: WAY_W] = '0;
      else if (hit) alloc_d[a*WAY_W +: WAY_W] = alloc_q[a*WAY_W +: WAY_W] + grant_cnt;
    end

    // committed copy takes the post-grant value in one step
    always_comb begin
      ways_d[a*WAY_W +: WAY_W] = ways_q[a*WAY_W +: WAY_W];
      if (commit) ways_d[a*WAY_W +: WAY_W] = alloc_d[a*WAY_W +: WAY_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_q <= '0;
      ways_q  <= '0;
    end else begin
      alloc_q <= alloc_d;
      ways_q  <= ways_d;
    end
  end

  assign alloc_cur = alloc_q;
  assign ways_out  = ways_q;

  // R8: committed values move only on a commit
  assert_commit_atomic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ways_q));

endmodule

// File: rtl/way_lookahead_alloc.sv
module way_lookahead_alloc #(
  parameter int NUM_APPS = 4,
  parameter int NUM_WAYS = 16,
  parameter int CNT_W    = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         start,
  output logic                                         rd_en,
  output logic [((NUM_APPS > 1) ? $clog2(NUM_APPS) : 1)-1:0] rd_app,
  output logic [$clog2(NUM_WAYS+1)-1:0]                rd_pos,
  input  logic [CNT_W-1:0]                             rd_data,
  output logic                                         done,
  output logic [NUM_APPS*$clog2(NUM_WAYS+1)-1:0]       ways_given
);

  import way_alloc_pkg::*;

  localparam int WAY_W = $clog2(NUM_WAYS + 1);
  localparam int APP_W = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1;
  localparam int SUM_W = WAY_W + APP_W + 1;
  localparam logic [APP_W-1:0] LAST_APP = APP_W'(NUM_APPS - 1);

  logic rst_sn;

  wa_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  // sequencer state
  wa_state_e        state_q, state_d;
  logic [APP_W-1:0] app_q, app_d;
  logic [WAY_W-1:0] dcnt_q, dcnt_d;
  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] bestg_q, bestg_d;
  logic [WAY_W-1:0] bestd_q, bestd_d;
  logic [APP_W-1:0] besta_q, besta_d;
  logic [APP_W-1:0] rr_q, rr_d;
  logic [WAY_W-1:0] rem_q, rem_d;
  logic             done_q, done_d;

  // allocation register interface
  logic                      clr;
  logic                      grant_en;
  logic [APP_W-1:0]          grant_app;
  logic [WAY_W-1:0]          grant_cnt;
  logic                      commit;
  logic [NUM_APPS*WAY_W-1:0] alloc_cur;
  logic [WAY_W-1:0]          cur_alloc;
  logic [CNT_W-1:0]          gain;
  logic                      better;

  wa_alloc_regs #(
    .NUM_APPS (NUM_APPS),
    .WAY_W    (WAY_W),
    .APP_W    (APP_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .clr       (clr),
    .grant_en  (grant_en),
    .grant_app (grant_app),
    .grant_cnt (grant_cnt),
    .commit    (commit),
    .alloc_cur (alloc_cur),
    .ways_out  (ways_given)
  );

  assign cur_alloc = alloc_cur[app_q*WAY_W +: WAY_W];

  // read port addressing
  always_comb begin
    rd_app = app_q;
    rd_pos = '0;
    rd_en  = 1'b0;
    if (state_q == ST_BASE) begin
      rd_pos = cur_alloc;
      rd_en  = (cur_alloc != '0);
    end else if (state_q == ST_SCAN) begin
      rd_pos = cur_alloc + dcnt_q;
      rd_en  = 1'b1;
    end
  end

  // hits gained over the base, floored at zero
  assign gain = (rd_data >= base_q) ? (rd_data - base_q) : '0;

  wa_mu_compare #(
    .CNT_W (CNT_W),
    .WAY_W (WAY_W)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cand_gain (gain),
    .cand_ways (dcnt_q),
    .best_gain (bestg_q),
    .best_ways (bestd_q),
    .better    (better)
  );

  // grant selection: best candidate, or one way by rotation when nothing gains
  always_comb begin
    if (bestg_q == '0) begin
      grant_app = rr_q;
      grant_cnt = WAY_W'(1);
    end else begin
      grant_app = besta_q;
      grant_cnt = bestd_q;
    end
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    app_d    = app_q;
    dcnt_d   = dcnt_q;
    base_d   = base_q;
    bestg_d  = bestg_q;
    bestd_d  = bestd_q;
    besta_d  = besta_q;
    rr_d     = rr_q;
    rem_d    = rem_q;
    done_d   = done_q;
    clr      = 1'b0;
    grant_en = 1'b0;
    commit   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          clr     = 1'b1;
          rem_d   = WAY_W'(NUM_WAYS);
          rr_d    = '0;
          app_d   = '0;
          bestg_d = '0;
          bestd_d = WAY_W'(1);
          besta_d = '0;
          done_d  = 1'b0;
          state_d = ST_BASE;
        end
      end
      ST_BASE: begin
        base_d  = (cur_alloc == '0) ? '0 : rd_data;
        dcnt_d  = WAY_W'(1);
        state_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (better) begin
          bestg_d = gain;
          bestd_d = dcnt_q;
          besta_d = app_q;
        end
        if (dcnt_q == rem_q) begin
          if (app_q == LAST_APP) begin
            state_d = ST_GRANT;
          end else begin
            app_d   = app_q + APP_W'(1);
            state_d = ST_BASE;
          end
        end else begin
          dcnt_d = dcnt_q + WAY_W'(1);
        end
      end
      ST_GRANT: begin
        grant_en = 1'b1;
        rem_d    = rem_q - grant_cnt;
        if (bestg_q == '0) rr_d = (rr_q == LAST_APP) ? '0 : rr_q + APP_W'(1);
        if (rem_q == grant_cnt) begin
          commit  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          app_d   = '0;
          bestg_d = '0;
          bestd_d = WAY_W'(1);
          besta_d = '0;
          state_d = ST_BASE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      app_q   <= '0;
      dcnt_q  <= '0;
      base_q  <= '0;
      bestg_q <= '0;
      bestd_q <= WAY_W'(1);
      besta_q <= '0;
      rr_q    <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      app_q   <= app_d;
      dcnt_q  <= dcnt_d;
      base_q  <= base_d;
      bestg_q <= bestg_d;
      bestd_q <= bestd_d;
      besta_q <= besta_d;
      rr_q    <= rr_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  // checker sums
  logic [SUM_W-1:0] alloc_sum;
  logic [SUM_W-1:0] given_sum;
  always_comb begin
    alloc_sum = '0;
    given_sum = '0;
    for (int a = 0; a < NUM_APPS; a++) begin
      alloc_sum = alloc_sum + SUM_W'(alloc_cur[a*WAY_W +: WAY_W]);
      given_sum = given_sum + SUM_W'(ways_given[a*WAY_W +: WAY_W]);
    end
  end

  // R6: granted plus remaining ways always equals the budget during a pass
  assert_budget_kept_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q != ST_IDLE) |-> (alloc_sum + SUM_W'(rem_q) == SUM_W'(NUM_WAYS)));

  // R6: a grant never exceeds what remains
  assert_grant_fits_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_GRANT) |-> (grant_cnt <= rem_q) && (grant_cnt != '0));

  // R9: read address stays on the curve
  assert_rd_range_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_en |-> (rd_pos >= WAY_W'(1)) && (rd_pos <= WAY_W'(NUM_WAYS)));

  // R2: completed result covers every way
  assert_done_total_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(done_q) |-> (given_sum == SUM_W'(NUM_WAYS)));

  // R2: an accepted start drops done
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (start && state_q == ST_IDLE) |=> !done_q);

endmodule

// File: tb/way_lookahead_alloc_tb.sv
`timescale 1ns/1ps
module way_lookahead_alloc_tb;

  localparam int NA    = 4;
  localparam int NW    = 8;
  localparam int CW    = 12;
  localparam int WW    = $clog2(NW + 1);
  localparam int AW    = $clog2(NA);

  logic               clk;
  logic               rst_n;
  logic               start;
  logic               rd_en;
  logic [AW-1:0]      rd_app;
  logic [WW-1:0]      rd_pos;
  logic [CW-1:0]      rd_data;
  logic               done;
  logic [NA*WW-1:0]   ways_given;

  way_lookahead_alloc #(.NUM_APPS(NA), .NUM_WAYS(NW), .CNT_W(CW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_en      (rd_en),
    .rd_app     (rd_app),
    .rd_pos     (rd_pos),
    .rd_data    (rd_data),
    .done       (done),
    .ways_given (ways_given)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int curves [NA][NW+1];
  int exp_w  [NA];
  int prev_w [NA];
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // monitor read port model
  always_comb begin
    if (rd_pos == '0 || int'(rd_pos) > NW) rd_data = '0;
    else rd_data = CW'(curves[int'(rd_app)][int'(rd_pos)]);
  end

  function automatic int field(input int a);
    return int'(ways_given[a*WW +: WW]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference allocation computed from the requirements
  function automatic void model();
    int alloc [NA];
    int rem, rr;
    longint bg, bd, g, base, v;
    int ba;
    for (int a = 0; a < NA; a++) alloc[a] = 0;
    rem = NW; rr = 0;
    while (rem > 0) begin
      bg = 0; bd = 1; ba = 0;
      for (int a = 0; a < NA; a++) begin
        base = (alloc[a] == 0) ? 0 : curves[a][alloc[a]];
        for (int d = 1; d <= rem; d++) begin
          v = curves[a][alloc[a] + d];
          g = (v >= base) ? v - base : 0;
          if (g * bd > bg * d) begin bg = g; bd = d; ba = a; end
        end
      end
      if (bg == 0) begin
        alloc[rr]++; rem--; rr = (rr + 1) % NA;
      end else begin
        alloc[ba] += int'(bd); rem -= int'(bd);
      end
    end
    for (int a = 0; a < NA; a++) exp_w[a] = alloc[a];
  endfunction

  // runs one pass; extra_start pulses start again mid-pass
  task automatic run_pass(input string tag, input bit extra_start);
    int n;
    bit held;
    bit dmatch;
    int sum;
    model();
    for (int a = 0; a < NA; a++) prev_w[a] = field(a);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R2 done low after start", int'(done), 0);
    held = 1; n = 0;
    while (!done && n < 3000) begin
      if (extra_start && n == 5) start = 1'b1;
      if (extra_start && n == 6) start = 1'b0;
      for (int a = 0; a < NA; a++) if (field(a) != prev_w[a]) held = 0;
      @(negedge clk); n++;
    end
    start = 1'b0;
    check(done == 1'b1, "R2 pass completes", int'(done), 1);
    check(held, "R8 outputs held during pass", int'(held), 1);
    sum = 0; dmatch = 1;
    for (int a = 0; a < NA; a++) begin
      sum += field(a);
      if (field(a) != exp_w[a]) begin
        dmatch = 0;
        $display("FAIL %s app%0d actual=%0d expected=%0d", tag, a, field(a), exp_w[a]);
      end
    end
    checks++; if (!dmatch) errors++;
    check(sum == NW, "R2 total ways", sum, NW);
  endtask

  task automatic expect_ways(input string tag, input int e0, input int e1, input int e2, input int e3);
    int e [NA];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    for (int a = 0; a < NA; a++) check(field(a) == e[a], tag, field(a), e[a]);
  endtask

  task automatic set_zero();
    for (int a = 0; a < NA; a++) for (int k = 0; k <= NW; k++) curves[a][k] = 0;
  endtask

  initial begin
    int acc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0;
    set_zero();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(rd_en == 1'b0, "R1 rd_en after reset", int'(rd_en), 0);
    check(ways_given == '0, "R1 ways after reset", int'(ways_given), 0);

    // R3 R4: late jump on app1 must win over steady app0
    set_zero();
    for (int k = 1; k <= NW; k++) begin
      curves[0][k] = 10 * k;
      curves[1][k] = (k >= 3) ? 80 : 0;
    end
    run_pass("R4 lookahead", 0);
    expect_ways("R4 lookahead field", 5, 3, 0, 0);

    // R7: no gain anywhere, rotation deals two each
    set_zero();
    run_pass("R7 all zero", 0);
    expect_ways("R7 rotation field", 2, 2, 2, 2);

    // R5: identical straight curves, lowest app and smallest size win
    for (int a = 0; a < NA; a++) for (int k = 0; k <= NW; k++) curves[a][k] = 5 * k;
    run_pass("R5 ties", 0);
    expect_ways("R5 tie field", 8, 0, 0, 0);

    // R3 R7: falling curve floored at zero, then rotation from app0
    set_zero();
    curves[0][1] = 50;
    for (int k = 2; k <= NW; k++) curves[0][k] = 20;
    run_pass("R3 falling", 0);
    expect_ways("R3 falling field", 3, 2, 2, 1);

    // R4 exact ratio: 7 over 3 ways beats 2 per way
    set_zero();
    for (int k = 1; k <= NW; k++) begin
      curves[0][k] = 2 * k;
      curves[1][k] = (k >= 3) ? 7 : 0;
    end
    run_pass("R4 exact ratio", 0);
    expect_ways("R4 ratio field", 5, 3, 0, 0);

    // R10: start during a pass is ignored
    for (int a = 0; a < NA; a++) begin
      acc = 0;
      curves[a][0] = 0;
      for (int k = 1; k <= NW; k++) begin acc += $urandom_range(0, 60); curves[a][k] = acc; end
    end
    run_pass("R10 mid-pass start", 1);

    // R6 randomized curves
    for (int p = 0; p < 24; p++) begin
      for (int a = 0; a < NA; a++) begin
        acc = 0;
        curves[a][0] = 0;
        for (int k = 1; k <= NW; k++) begin
          if ($urandom_range(0, 7) == 0) acc = (acc > 30) ? acc - 30 : 0;
          else if ($urandom_range(0, 3) == 0) acc += $urandom_range(0, 200);
          else acc += $urandom_range(0, 20);
          curves[a][k] = acc;
        end
      end
      run_pass("R6 random", 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule